// File: doc/BRIEF.md
# Error Status Register with Edge-Triggered Message Request

This block holds a row of sticky error flags, one for each error source. An error event sets its flag. Software reads the whole row through a simple register port and clears flags by writing ones to them. A flag is recorded whether or not reporting is turned on, so software always sees every error that has occurred since it last cleared that flag.

A message request toward the system-error transport is raised only when a flag goes from clear to set. That bit's mask enable and the global enable must both be on at the moment it goes high. A flag that stays high never reports twice. Transitions that land together, or that land while a request is already waiting, are merged into one request. The request carries a cause vector of the bits that caused it, and it stays up until the transport acknowledges it.

The block has two resets. A power-on reset clears everything. A warm reset drops any pending request but leaves the flags as they are.

Top module: `esr_status_top`

## Requirements
- R1: After a power-on reset (`por_n` low at a clock edge), `rd_data`, `msg_req` and `msg_cause` are all zero.
- R2: An `err_evt` bit that is high at a clock edge sets the matching flag, visible on `rd_data` after that edge, whatever the values of `bit_en` and `glb_en`.
- R3: A write (`wr_en` high) clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 keep their value, and a flag changes only through an event or a write of 1.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the flag ends up set.
- R5: When a flag goes from 0 to 1 at an edge while its `bit_en` bit and `glb_en` are high (and `wrst_n` is high), `msg_req` is 1 after that edge and `msg_cause` contains that bit.
- R6: A 0-to-1 transition whose `bit_en` bit or `glb_en` is low at that edge raises no request and adds nothing to `msg_cause`.
- R7: A flag that is already set and receives further events produces no new request and no new cause bit.
- R8: Qualified transitions on several bits at the same edge produce a single request whose `msg_cause` holds all of those bits.
- R9: `msg_req` stays high until an edge where `msg_ack` is high. Qualified transitions while it is pending are ORed into `msg_cause`. At the acknowledging edge, the request drops and `msg_cause` returns to zero, unless transitions arrive at that same edge; then the request stays high with `msg_cause` equal to just the new bits.
- R10: A warm reset (`wrst_n` low at an edge) clears `msg_req` and `msg_cause` and keeps the flags. Events during warm reset still set flags but raise no request.
- R11: `msg_req` is high exactly when `msg_cause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| wrst_n | input | 1 | Warm reset, synchronous, active low; clears the message logic only |
| err_evt | input | W (16) | Error event pulses, one per flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | W (16) | Write data; a 1 clears the matching flag |
| rd_data | output | W (16) | Current flag values |
| bit_en | input | W (16) | Per-flag reporting enable |
| glb_en | input | 1 | Global reporting enable |
| msg_req | output | 1 | System-error message request, held until acknowledged |
| msg_ack | input | 1 | Acknowledge from the message transport |
| msg_cause | output | W (16) | Flags whose rising edges the pending request covers |

## Verification
The assertions assume that `msg_ack` means something only while `msg_req` is high. They also assume that the enables sampled at the edge where a flag rises are the ones that decide whether it reports. The stimulus drives all inputs on the falling clock edge, so every edge sees stable values. Acknowledges come at random, including in cycles with no pending request, where they must be ignored. Events are kept sparse by ANDing several random words together, so that rising edges, already-set bits, merges and clears in the same cycle all occur often enough to matter.

// File: rtl/esr_pkg.sv
// Package: shared types and defaults for the error status register.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package esr_pkg;

    // Default number of error flags
    localparam int ESR_W_DEF = 16;

    // Message request controller states
    typedef enum logic {
        MSG_IDLE = 1'b0,
        MSG_PEND = 1'b1
    } msg_state_e;

endpackage

// File: rtl/esr_flag_bank.sv
// Module: sticky flag bank. Events set flags, clear vector clears them, set wins.
// Assumes: only the power-on reset reaches this bank; warm reset must not.
module esr_flag_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags_q,
    output logic [W-1:0] flags_nxt
);

    // Next flag value: clear first, then events override
    always_comb begin
        flags_nxt = (flags_q & ~clr_vec) | set_vec;
    end

    // Flag storage, cleared only at power-on
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_nxt;
        end
    end

endmodule

// File: rtl/esr_edge_qual.sv
// Module: per-bit rising-edge detector and reporting qualifier.
// Assumes: flags_nxt is the value the bank will load at the coming edge, so a
// rising edge is reported in the same edge that sets the flag.
module esr_edge_qual #(
    parameter int W = 16
) (
    input  logic [W-1:0] flags_cur,
    input  logic [W-1:0] flags_nxt,
    input  logic [W-1:0] bit_en,
    input  logic         glb_en,
    input  logic         arm,
    output logic [W-1:0] trig
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // One bit: clear-to-set, enabled per bit and globally, and armed
            assign trig[gi] = flags_nxt[gi] & ~flags_cur[gi] & bit_en[gi] & glb_en & arm;
        end
    endgenerate

endmodule

// File: rtl/esr_msg_ctrl.sv
// Module: message request holder. Raises a request on any trigger, holds it
// until acknowledged, and merges later triggers into the cause vector.
// Assumes: ack is ignored while no request is pending; triggers landing on the
// acknowledging edge open a fresh request.
module esr_msg_ctrl #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] trig,
    input  logic         ack,
    output logic         req,
    output logic [W-1:0] cause
);
    import esr_pkg::*;

    msg_state_e state_q;
    logic       any_trig;

    // Any qualified rising edge this cycle
    always_comb begin
        any_trig = |trig;
    end

    // Request state and cause accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MSG_IDLE;
            cause   <= '0;
        end else begin
            case (state_q)
                MSG_IDLE: begin
                    if (any_trig) begin
                        state_q <= MSG_PEND;
                        cause   <= trig;
                    end
                end
                MSG_PEND: begin
                    if (ack) begin
                        state_q <= any_trig ? MSG_PEND : MSG_IDLE;
                        cause   <= trig;
                    end else begin
                        cause   <= cause | trig;
                    end
                end
                default: begin
                    state_q <= MSG_IDLE;
                    cause   <= '0;
                end
            endcase
        end
    end

    // Request output decoded from state
    always_comb begin
        req = (state_q == MSG_PEND);
    end

endmodule

// File: rtl/esr_status_top.sv
// Module: error status register top. Sticky flags with write-1-to-clear,
// edge-triggered message request with per-bit and global enables.
// Assumes: synchronous active-low resets; por_n clears all, wrst_n clears only
// the message path.
module esr_status_top #(
    parameter int W = esr_pkg::ESR_W_DEF
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         wrst_n,
    input  logic [W-1:0] err_evt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] bit_en,
    input  logic         glb_en,
    output logic         msg_req,
    input  logic         msg_ack,
    output logic [W-1:0] msg_cause
);

    logic [W-1:0] clr_vec;
    logic [W-1:0] flags_q;
    logic [W-1:0] flags_nxt;
    logic [W-1:0] trig;
    logic         msg_rst_n;

    // Software clear vector, active only on a write
    always_comb begin
        clr_vec = wr_en ? wr_data : '0;
    end

    // Message path resets on either reset
    always_comb begin
        msg_rst_n = por_n & wrst_n;
    end

    esr_flag_bank #(.W(W)) u_bank (
        .clk       (clk),
        .por_n     (por_n),
        .set_vec   (err_evt),
        .clr_vec   (clr_vec),
        .flags_q   (flags_q),
        .flags_nxt (flags_nxt)
    );

    esr_edge_qual #(.W(W)) u_qual (
        .flags_cur (flags_q),
        .flags_nxt (flags_nxt),
        .bit_en    (bit_en),
        .glb_en    (glb_en),
        .arm       (wrst_n),
        .trig      (trig)
    );

    esr_msg_ctrl #(.W(W)) u_msg (
        .clk   (clk),
        .rst_n (msg_rst_n),
        .trig  (trig),
        .ack   (msg_ack),
        .req   (msg_req),
        .cause (msg_cause)
    );

    // Read port shows the flags directly
    always_comb begin
        rd_data = flags_q;
    end

endmodule

// File: rtl/esr_status_chk.sv
// Module: assertion checker for esr_status_top, bound to every instance.
// Assumes: inputs are stable around the rising clock edge.
module esr_status_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         por_n,
    input logic         wrst_n,
    input logic [W-1:0] err_evt,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] bit_en,
    input logic         glb_en,
    input logic         msg_req,
    input logic         msg_ack,
    input logic [W-1:0] msg_cause
);

    // R2: an event always lands in its flag
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!por_n)
        (|err_evt) |=> ((rd_data & $past(err_evt)) == $past(err_evt)));

    // R3: without a write, no flag falls
    a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

    // R3: a written 1 clears its flag unless an event hits that bit too
    a_r3_write_one_clears: assert property (@(posedge clk) disable iff (!por_n)
        wr_en |=> ((rd_data & $past(wr_data & ~err_evt)) == '0));

    // R5: a qualified rising edge raises a request
    a_r5_edge_raises: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
        ((|(err_evt & ~rd_data & bit_en)) && glb_en) |=> msg_req);

    // R7: with no fresh rising edge, an idle request stays idle
    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!por_n)
        (!msg_req && ((err_evt & ~rd_data) == '0)) |=> !msg_req);

    // R9: a request without acknowledge is held
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
        (msg_req && !msg_ack) |=> msg_req);

    // R9: pending cause bits survive until acknowledge
    a_r9_cause_merges: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
        (msg_req && !msg_ack) |=> ((msg_cause & $past(msg_cause)) == $past(msg_cause)));

    // R10: warm reset drops the request
    a_r10_warm_drops_req: assert property (@(posedge clk) disable iff (!por_n)
        !wrst_n |=> (!msg_req && msg_cause == '0));

    // R11: request and cause agree
    a_r11_req_matches_cause: assert property (@(posedge clk) disable iff (!por_n)
        msg_req == (msg_cause != '0));

endmodule

bind esr_status_top esr_status_chk #(.W(W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .wrst_n    (wrst_n),
    .err_evt   (err_evt),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .bit_en    (bit_en),
    .glb_en    (glb_en),
    .msg_req   (msg_req),
    .msg_ack   (msg_ack),
    .msg_cause (msg_cause)
);

// File: tb/esr_status_top_bench.sv
// Bench: directed corner cases followed by seeded random traffic, each cycle
// checked against a reference model built from the requirements.
module esr_status_top_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         wrst_n = 1'b1;
    logic [W-1:0] err_evt = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] bit_en = '0;
    logic         glb_en = 1'b0;
    logic         msg_req;
    logic         msg_ack = 1'b0;
    logic [W-1:0] msg_cause;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] m_flags = '0;
    logic         m_req = 1'b0;
    logic [W-1:0] m_cause = '0;

    always #5 clk = ~clk;

    esr_status_top #(.W(W)) u_esr_status_top (
        .clk       (clk),
        .por_n     (por_n),
        .wrst_n    (wrst_n),
        .err_evt   (err_evt),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .bit_en    (bit_en),
        .glb_en    (glb_en),
        .msg_req   (msg_req),
        .msg_ack   (msg_ack),
        .msg_cause (msg_cause)
    );

    // Model: flag update, set beats clear (R2, R3, R4)
    function automatic logic [W-1:0] nxt_flags(input logic [W-1:0] f, input logic [W-1:0] ev,
                                              input logic wr, input logic [W-1:0] wd);
        return (f & ~(wr ? wd : '0)) | ev;
    endfunction

    // Model: qualified rising edges (R5, R6, R7, R10)
    function automatic logic [W-1:0] rise_bits(input logic [W-1:0] f, input logic [W-1:0] fn,
                                              input logic [W-1:0] ben, input logic gen,
                                              input logic wrst);
        if (!wrst || !gen) return '0;
        return fn & ~f & ben;
    endfunction

    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance, check at the next falling edge
    task automatic step(input logic [W-1:0] ev, input logic wr, input logic [W-1:0] wd,
                        input logic [W-1:0] ben, input logic gen, input logic ack,
                        input logic wrst, input string tag);
        logic [W-1:0] fn;
        logic [W-1:0] tr;
        err_evt = ev; wr_en = wr; wr_data = wd; bit_en = ben;
        glb_en = gen; msg_ack = ack; wrst_n = wrst;
        fn = nxt_flags(m_flags, ev, wr, wd);
        tr = rise_bits(m_flags, fn, ben, gen, wrst);
        m_flags = fn;
        if (!wrst) begin
            m_req = 1'b0; m_cause = '0;
        end else if (m_req && ack) begin
            m_req = (tr != '0); m_cause = tr;
        end else if (m_req) begin
            m_cause = m_cause | tr;
        end else if (tr != '0) begin
            m_req = 1'b1; m_cause = tr;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "flags", rd_data, m_flags);
        chk(tag, "req", {{(W-1){1'b0}}, msg_req}, {{(W-1){1'b0}}, m_req});
        chk(tag, "cause", msg_cause, m_cause);
    endtask

    task automatic power_on;
        por_n = 1'b0; wrst_n = 1'b1; err_evt = '1; wr_en = 1'b0; msg_ack = 1'b0;
        glb_en = 1'b1; bit_en = '1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        err_evt = '0; por_n = 1'b1;
        m_flags = '0; m_req = 1'b0; m_cause = '0;
        chk("R1", "flags", rd_data, '0);
        chk("R1", "req", {{(W-1){1'b0}}, msg_req}, '0);
        chk("R1", "cause", msg_cause, '0);
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        @(negedge clk);
        power_on();

        // R2 R6: flag latches with global enable off, no request
        step(16'h0001, 0, '0, '1, 0, 0, 1, "R2_R6 gen off");
        // R3: writing zeros has no effect, writing a one clears
        step('0, 1, 16'h0000, '1, 0, 0, 1, "R3 write zero");
        step('0, 1, 16'h0001, '1, 0, 0, 1, "R3 write one");
        // R5: qualified rising edge raises request with cause
        step(16'h0008, 0, '0, '1, 1, 0, 1, "R5 raise");
        // R7 R9: repeat event on set flag, request held without ack
        step(16'h0008, 0, '0, '1, 1, 0, 1, "R7_R9 hold");
        // R9: new edge while pending merges
        step(16'h0020, 0, '0, '1, 1, 0, 1, "R9 merge");
        step('0, 0, '0, '1, 1, 1, 1, "R9 ack");
        // R7: event on a still-set flag after ack gives nothing
        step(16'h0008, 0, '0, '1, 1, 0, 1, "R7 set flag");
        // R4: clear and event on same bit, set wins, no edge
        step(16'h0008, 1, 16'h0008, '1, 1, 0, 1, "R4 set wins");
        // R4 R5: clear plus event on a clear bit rises
        step(16'h0100, 1, 16'h0100, '1, 1, 0, 1, "R4_R5 clear bit");
        step('0, 0, '0, '1, 1, 1, 1, "R9 ack2");
        // R8: several bits together, one request
        step(16'h0016, 0, '0, '1, 1, 0, 1, "R8 multi");
        // R9: ack with a new edge in the same cycle
        step(16'h0040, 0, '0, '1, 1, 1, 1, "R9 ack+new");
        step('0, 0, '0, '1, 1, 1, 1, "R9 ack3");
        // R9: ack with nothing pending is ignored
        step('0, 0, '0, '1, 1, 1, 1, "R9 idle ack");
        // R6: bit enable off for bit 7
        step(16'h0080, 0, '0, 16'hFF7F, 1, 0, 1, "R6 bit mask");
        // R10: pending request, then warm reset with an event
        step(16'h0200, 0, '0, '1, 1, 0, 1, "R10 pend");
        step(16'h0400, 0, '0, '1, 1, 0, 0, "R10 warm");
        step('0, 0, '0, '1, 1, 0, 1, "R10 after");
        // R11 and everything: seeded random traffic
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ev;
            logic [W-1:0] wd;
            ev = W'($urandom) & W'($urandom) & W'($urandom);
            wd = W'($urandom);
            step(ev, ($urandom % 4) == 0, wd, W'($urandom) | W'($urandom),
                 ($urandom % 8) != 0, ($urandom % 3) == 0, ($urandom % 50) != 0,
                 "R2_R3_R5_R9_R11 random");
        end
        // R1: power-on reset clears sticky flags
        power_on();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule